// File: doc/BRIEF.md
# Shared Load/Store Bus Manager

This block is the data-side bus manager of a processor. It turns load and store requests into single AHB5 transfers and shares the same port with a debugger's system-bus requester. Each requester drives an address, a write flag, a two-bit size (0 byte, 1 halfword, 2 word), a valid and write data. It holds these stable until it sees `ready`. The block keeps at most one transfer outstanding per requester. When both requesters could start in the same cycle, the debugger goes first. Transfers from the two requesters are told apart by the manager ID on `hmaster`.

The block places write data on the byte lanes the access uses. It returns read data shifted down and zero-extended. It handles wait states and the two-cycle error response, and it passes the exclusive-access status back to the core. Only IDLE and NONSEQ transfer types are produced. Bursts and bus locking are never used.

Top module: `ldst_ahb_manager`

## Requirements
- R1: `htrans` is only 0 (IDLE) or 2 (NONSEQ). `hburst` is always 0 (SINGLE) and `hmastlock` is always 0.
- R2: In a NONSEQ address phase, `haddr` is the granted requester's address and `hsize` is {0, size}. The address is naturally aligned for that size.
- R3: `hprot[3:2]` are 0 and `hprot[0]` is 1. `hprot[1]` equals `core_priv` for a core transfer and is 1 for a debug transfer.
- R4: `hmaster` is 0x00 for a core transfer and 0x01 for a debug transfer.
- R5: A requester may start a transfer if it is valid and does not own the current data phase. When both may start, the debug transfer is issued. The core is issued at the next address phase that is free.
- R6: During a write data phase, `hwdata` holds the write data masked to the access size and shifted left by 8×addr[1:0]. All other lanes are 0.
- R7: When a read completes without error, the owner's read data is `hrdata` shifted right by 8×addr[1:0] and zero-extended above the access size.
- R8: While `hready` is low, no requester gets `ready`. A NONSEQ address phase that is not accepted keeps the same address and type in the next cycle, unless an error response starts.
- R9: In the first error cycle (`hresp`=1, `hready`=0), the address phase is driven IDLE. In the second cycle, only the requester that owns the data phase gets `ready` together with `err`.
- R10: `hexcl` is 1 only for a core transfer with `core_excl` set. `core_exokay` is 1 on the successful completion of such a transfer when `hexokay` is 1.
- R11: After reset, no data phase is active: `htrans` is IDLE while no requester is valid, and no `ready` is given.
- R12: `ready` goes only to the owner of the completing data phase. A requester is never issued again while it owns the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| core_addr | input | 32 | Core byte address |
| core_write | input | 1 | Core write flag (1 write, 0 read) |
| core_size | input | 2 | Core size: 0 byte, 1 halfword, 2 word |
| core_priv | input | 1 | Core privileged access |
| core_excl | input | 1 | Core exclusive access |
| core_valid | input | 1 | Core request valid |
| core_wdata | input | 32 | Core write data, low-aligned |
| core_ready | output | 1 | Core transfer finished |
| core_err | output | 1 | Core transfer ended in error |
| core_exokay | output | 1 | Core exclusive transfer succeeded |
| core_rdata | output | 32 | Core read data, low-aligned |
| dbg_addr | input | 32 | Debug byte address |
| dbg_write | input | 1 | Debug write flag |
| dbg_size | input | 2 | Debug size: 0 byte, 1 halfword, 2 word |
| dbg_valid | input | 1 | Debug request valid |
| dbg_wdata | input | 32 | Debug write data, low-aligned |
| dbg_ready | output | 1 | Debug transfer finished |
| dbg_err | output | 1 | Debug transfer ended in error |
| dbg_rdata | output | 32 | Debug read data, low-aligned |
| haddr | output | 32 | Bus address |
| hwrite | output | 1 | Bus write flag |
| htrans | output | 2 | Bus transfer type |
| hsize | output | 3 | Bus transfer size |
| hburst | output | 3 | Bus burst type |
| hprot | output | 4 | Bus protection attributes |
| hmastlock | output | 1 | Bus lock |
| hmaster | output | 8 | Manager ID |
| hexcl | output | 1 | Exclusive transfer |
| hwdata | output | 32 | Bus write data |
| hready | input | 1 | Transfer done / data phase extended when low |
| hresp | input | 1 | Error response |
| hexokay | input | 1 | Exclusive success |
| hrdata | input | 32 | Bus read data |

## Verification
If the data-phase owner register holds the wrong value, the wrong requester gets `ready`, `err` or read data in the very cycle the transfer completes. If the hold state is wrong, the address or the manager ID changes while `hready` is low, or the error cancel is missed. Both show on the next bus cycle. If the lane offset or size captured for the data phase is wrong, `hwdata` is wrong during that whole data phase, and read data is wrong at completion. The bench models a subordinate that inserts random wait states, errors and exclusive results. Every address phase and every data phase is compared with a model of the requirements.

// File: rtl/ldst_ahb_pkg.sv
// Shared encodings and types for the load/store bus manager.
// Assumes a 32-bit bus and 2-bit requester sizes.
package ldst_ahb_pkg;
    typedef enum logic [1:0] {
        TRANS_IDLE = 2'b00,
        TRANS_NSEQ = 2'b10
    } trans_e;

    typedef enum logic {
        SRC_CORE = 1'b0,
        SRC_DBG  = 1'b1
    } src_e;

    localparam logic [2:0] BURST_SINGLE = 3'b000;
endpackage

// File: rtl/ldst_arbiter.sv
// Chooses which requester drives the next address phase.
// Assumes requesters hold their requests until served. A request that
// waits under a low hready is held. An error's first cycle cancels.
module ldst_arbiter
    import ldst_ahb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_elig,
    input  logic dbg_elig,
    input  logic hold,
    input  src_e hold_src,
    input  logic cancel,
    output logic issue,
    output src_e grant_src
);
    // Grant: cancel beats hold, hold beats new arbitration, debug beats core.
    always_comb begin
        issue     = 1'b0;
        grant_src = SRC_CORE;
        if (cancel) begin
            issue = 1'b0;
        end else if (hold) begin
            issue     = 1'b1;
            grant_src = hold_src;
        end else if (dbg_elig) begin
            issue     = 1'b1;
            grant_src = SRC_DBG;
        end else if (core_elig) begin
            issue     = 1'b1;
            grant_src = SRC_CORE;
        end
    end

    assert_dbg_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_elig && core_elig && !hold && !cancel) |-> (issue && grant_src == SRC_DBG));

    assert_cancel_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> !issue);
endmodule

// File: rtl/ldst_lane_align.sv
// Byte-lane steering for a data phase. Write data is masked to the
// access size and moved up to its lanes. Read data is moved down and
// zero-extended. Assumes size 0/1/2 and a naturally aligned offset.
module ldst_lane_align #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_bus,
    output logic [DATA_W-1:0] wdata_bus,
    output logic [DATA_W-1:0] rdata_out
);
    logic [DATA_W-1:0] size_mask;
    logic [OFS_W+2:0]  shamt;

    // Mask: the bits an access of this size carries.
    always_comb begin
        case (size)
            2'd0:    size_mask = DATA_W'(8'hFF);
            2'd1:    size_mask = DATA_W'(16'hFFFF);
            default: size_mask = '1;
        endcase
    end

    // Shift both directions by the byte offset.
    always_comb begin
        shamt     = {ofs, 3'b000};
        wdata_bus = (wdata_in & size_mask) << shamt;
        rdata_out = (rdata_bus >> shamt) & size_mask;
    end
endmodule

// File: rtl/ldst_ahb_manager.sv
// AHB5 data manager shared by the core load/store path and a debug
// system-bus requester. One transfer is outstanding per requester.
// Assumes requesters hold their requests stable until ready and give
// naturally aligned addresses with size 0..2.
module ldst_ahb_manager
    import ldst_ahb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter logic [7:0] CORE_ID = 8'h00,
    parameter logic [7:0] DBG_ID  = 8'h01,
    localparam int OFS_W = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_write,
    input  logic [1:0]        core_size,
    input  logic              core_priv,
    input  logic              core_excl,
    input  logic              core_valid,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ready,
    output logic              core_err,
    output logic              core_exokay,
    output logic [DATA_W-1:0] core_rdata,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic              dbg_write,
    input  logic [1:0]        dbg_size,
    input  logic              dbg_valid,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic              dbg_ready,
    output logic              dbg_err,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic [ADDR_W-1:0] haddr,
    output logic              hwrite,
    output logic [1:0]        htrans,
    output logic [2:0]        hsize,
    output logic [2:0]        hburst,
    output logic [3:0]        hprot,
    output logic              hmastlock,
    output logic [7:0]        hmaster,
    output logic              hexcl,
    output logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    input  logic              hresp,
    input  logic              hexokay,
    input  logic [DATA_W-1:0] hrdata
);
    // Data-phase state.
    logic              dp_v;
    src_e              dp_src;
    logic [OFS_W-1:0]  dp_ofs;
    logic [1:0]        dp_size;
    logic              dp_write;
    logic              dp_excl;
    logic [DATA_W-1:0] dp_wdata;
    // Address-phase hold state.
    logic              hold;
    src_e              hold_src;

    logic              issue, cancel, accept, done;
    src_e              grant_src;
    logic              sel_write, sel_priv, sel_excl;
    logic [1:0]        sel_size;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic [DATA_W-1:0] rdata_al;

    // Cancel the queued address phase in the first error cycle.
    assign cancel = dp_v && hresp && !hready;

    ldst_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_elig (core_valid && !(dp_v && dp_src == SRC_CORE)),
        .dbg_elig  (dbg_valid && !(dp_v && dp_src == SRC_DBG)),
        .hold      (hold),
        .hold_src  (hold_src),
        .cancel    (cancel),
        .issue     (issue),
        .grant_src (grant_src)
    );

    // Mux the granted request onto the address phase.
    always_comb begin
        if (grant_src == SRC_DBG) begin
            sel_addr  = dbg_addr;
            sel_write = dbg_write;
            sel_size  = dbg_size;
            sel_wdata = dbg_wdata;
            sel_priv  = 1'b1;
            sel_excl  = 1'b0;
        end else begin
            sel_addr  = core_addr;
            sel_write = core_write;
            sel_size  = core_size;
            sel_wdata = core_wdata;
            sel_priv  = core_priv;
            sel_excl  = core_excl;
        end
    end

    // Drive the address-phase bus outputs.
    always_comb begin
        htrans    = issue ? TRANS_NSEQ : TRANS_IDLE;
        haddr     = sel_addr;
        hwrite    = sel_write;
        hsize     = {1'b0, sel_size};
        hburst    = BURST_SINGLE;
        hprot     = {2'b00, sel_priv, 1'b1};
        hmastlock = 1'b0;
        hmaster   = (grant_src == SRC_DBG) ? DBG_ID : CORE_ID;
        hexcl     = issue && sel_excl;
    end

    assign accept = issue && hready;
    assign done   = dp_v && hready;

    // Advance the data phase and remember a stalled address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_v     <= 1'b0;
            dp_src   <= SRC_CORE;
            dp_ofs   <= '0;
            dp_size  <= '0;
            dp_write <= 1'b0;
            dp_excl  <= 1'b0;
            dp_wdata <= '0;
            hold     <= 1'b0;
            hold_src <= SRC_CORE;
        end else begin
            if (hready) begin
                dp_v <= accept;
            end
            if (accept) begin
                dp_src   <= grant_src;
                dp_ofs   <= sel_addr[OFS_W-1:0];
                dp_size  <= sel_size;
                dp_write <= sel_write;
                dp_excl  <= sel_excl;
                dp_wdata <= sel_wdata;
            end
            hold     <= issue && !hready;
            hold_src <= grant_src;
        end
    end

    ldst_lane_align #(.DATA_W(DATA_W)) u_lanes (
        .ofs       (dp_ofs),
        .size      (dp_size),
        .wdata_in  (dp_wdata),
        .rdata_bus (hrdata),
        .wdata_bus (hwdata),
        .rdata_out (rdata_al)
    );

    // Route the completion to the owner of the data phase.
    always_comb begin
        core_ready  = done && dp_src == SRC_CORE;
        dbg_ready   = done && dp_src == SRC_DBG;
        core_err    = core_ready && hresp;
        dbg_err     = dbg_ready && hresp;
        core_exokay = core_ready && dp_excl && hexokay && !hresp;
        core_rdata  = rdata_al;
        dbg_rdata   = rdata_al;
    end

    assert_trans_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TRANS_IDLE || htrans == TRANS_NSEQ));

    assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TRANS_NSEQ && hsize == 3'd1) |-> haddr[0] == 1'b0);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TRANS_NSEQ && !hready && !hresp) |=>
        ((htrans == TRANS_NSEQ && $stable(haddr) && $stable(hmaster)) || (hresp && !hready)));

    assert_one_owner_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_ready && dbg_ready));

    assert_excl_core_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hexcl |-> (hmaster == CORE_ID && htrans == TRANS_NSEQ));

    assert_no_reissue_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TRANS_NSEQ && hmaster == DBG_ID) |-> !(dp_v && dp_src == SRC_DBG));
endmodule

// File: tb/tb_ldst_ahb_manager.sv
module tb_ldst_ahb_manager;
    localparam int CLK_PERIOD = 10;
    localparam int NCYC = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] core_addr = '0, dbg_addr = '0, core_wdata = '0, dbg_wdata = '0;
    logic core_write = 0, core_priv = 0, core_excl = 0, core_valid = 0;
    logic dbg_write = 0, dbg_valid = 0;
    logic [1:0] core_size = '0, dbg_size = '0;
    logic core_ready, core_err, core_exokay, dbg_ready, dbg_err;
    logic [31:0] core_rdata, dbg_rdata, haddr, hwdata;
    logic hwrite, hmastlock, hexcl;
    logic [1:0] htrans;
    logic [2:0] hsize, hburst;
    logic [3:0] hprot;
    logic [7:0] hmaster;
    logic hready = 1, hresp = 0, hexokay = 0;
    logic [31:0] hrdata = '0;

    int total = 0, bad = 0;
    bit finished = 0;

    ldst_ahb_manager dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] smask(logic [1:0] s);
        return (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction
    function automatic logic [31:0] exp_wd(logic [31:0] d, logic [1:0] o, logic [1:0] s);
        return (d & smask(s)) << (8 * o);
    endfunction
    function automatic logic [31:0] exp_rd(logic [31:0] d, logic [1:0] o, logic [1:0] s);
        return (d >> (8 * o)) & smask(s);
    endfunction
    function automatic logic [31:0] rnd_addr(logic [1:0] s);
        logic [31:0] a = $urandom;
        return a & ~((32'd1 << s) - 32'd1);
    endfunction

    // Model state for the data phase and a held address phase.
    logic m_dp_v = 0, m_dp_src = 0, m_dp_write = 0, m_dp_excl = 0;
    logic [31:0] m_dp_addr = '0, m_dp_wdata = '0;
    logic [1:0] m_dp_size = '0;
    logic m_hold = 0, m_hold_src = 0;
    bit err_second = 0;

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24681));
        // R11: reset state.
        repeat (3) @(negedge clk);
        #1;
        chk("R11 htrans in reset", 32'(htrans), 32'd0);
        chk("R11 core_ready in reset", 32'(core_ready), 32'd0);
        chk("R11 dbg_ready in reset", 32'(dbg_ready), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R11 htrans idle after reset", 32'(htrans), 32'd0);
        chk("R11 no ready after reset", 32'({core_ready, dbg_ready}), 32'd0);

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            logic cancel, issue, src, exp_cr, exp_dr, pr;
            logic [1:0] s;
            @(negedge clk);
            // Subordinate response for this cycle.
            if (m_dp_v) begin
                int r = $urandom % 8;
                hrdata  = $urandom;
                hexokay = $urandom % 2;
                if (err_second) begin
                    hready = 1; hresp = 1; err_second = 0;
                end else if (r == 0) begin
                    hready = 0; hresp = 1; err_second = 1;
                end else if (r < 3) begin
                    hready = 0; hresp = 0;
                end else begin
                    hready = 1; hresp = 0;
                end
            end else begin
                hready = 1; hresp = 0;
            end
            // New requests; the first cycle has both requesters valid (R5).
            if (!core_valid && (cyc == 0 || $urandom % 3 == 0)) begin
                s = 2'($urandom % 3);
                core_size = s; core_addr = rnd_addr(s); core_write = $urandom % 2;
                core_wdata = $urandom; core_priv = $urandom % 2; core_excl = ($urandom % 4) == 0;
                core_valid = 1;
            end
            if (!dbg_valid && (cyc == 0 || $urandom % 4 == 0)) begin
                s = 2'($urandom % 3);
                dbg_size = s; dbg_addr = rnd_addr(s); dbg_write = $urandom % 2;
                dbg_wdata = $urandom; dbg_valid = 1;
            end
            #1;
            // Expected address phase.
            cancel = m_dp_v && hresp && !hready;
            issue = 0; src = 0;
            if (cancel) issue = 0;
            else if (m_hold) begin issue = 1; src = m_hold_src; end
            else if (dbg_valid && !(m_dp_v && m_dp_src)) begin issue = 1; src = 1; end
            else if (core_valid && !(m_dp_v && !m_dp_src)) begin issue = 1; src = 0; end
            if (cyc == 0) chk("R5 debug first when both valid", 32'(hmaster), 32'h01);
            chk(cancel ? "R9 idle in first error cycle" : "R1 htrans", 32'(htrans), issue ? 32'd2 : 32'd0);
            chk("R1 hburst", 32'(hburst), 32'd0);
            chk("R1 hmastlock", 32'(hmastlock), 32'd0);
            if (issue) begin
                pr = src ? 1'b1 : core_priv;
                chk("R2 haddr", haddr, src ? dbg_addr : core_addr);
                chk("R2 hsize", 32'(hsize), 32'(src ? dbg_size : core_size));
                chk("R2 hwrite", 32'(hwrite), 32'(src ? dbg_write : core_write));
                chk("R3 hprot", 32'(hprot), 32'({2'b00, pr, 1'b1}));
                chk("R4 R5 hmaster", 32'(hmaster), src ? 32'h01 : 32'h00);
                chk("R10 hexcl", 32'(hexcl), 32'(!src && core_excl));
            end else begin
                chk("R10 hexcl idle", 32'(hexcl), 32'd0);
            end
            // Expected data phase.
            exp_cr = m_dp_v && hready && !m_dp_src;
            exp_dr = m_dp_v && hready && m_dp_src;
            chk("R8 R12 core_ready", 32'(core_ready), 32'(exp_cr));
            chk("R8 R12 dbg_ready", 32'(dbg_ready), 32'(exp_dr));
            chk("R9 core_err", 32'(core_err), 32'(exp_cr && hresp));
            chk("R9 dbg_err", 32'(dbg_err), 32'(exp_dr && hresp));
            chk("R10 core_exokay", 32'(core_exokay), 32'(exp_cr && m_dp_excl && hexokay && !hresp));
            if (m_dp_v && m_dp_write)
                chk("R6 hwdata lanes", hwdata, exp_wd(m_dp_wdata, m_dp_addr[1:0], m_dp_size));
            if ((exp_cr || exp_dr) && !m_dp_write && !hresp)
                chk("R7 read data", exp_cr ? core_rdata : dbg_rdata,
                    exp_rd(hrdata, m_dp_addr[1:0], m_dp_size));
            // Model update for the coming edge.
            if (hready) begin
                m_dp_v = issue;
                if (issue) begin
                    m_dp_src   = src;
                    m_dp_addr  = src ? dbg_addr : core_addr;
                    m_dp_size  = src ? dbg_size : core_size;
                    m_dp_write = src ? dbg_write : core_write;
                    m_dp_wdata = src ? dbg_wdata : core_wdata;
                    m_dp_excl  = !src && core_excl;
                end
            end
            m_hold = issue && !hready;
            m_hold_src = src;
            @(posedge clk);
            #1;
            if (exp_cr) core_valid = 0;
            if (exp_dr) dbg_valid = 0;
        end
        finish_run();
    end
endmodule